// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a single-cycle execution datapath steered entirely by a flat control word presented on its inputs, one word per clock. A register file of 32 words of 32 bits supplies two operands (X and Y) through independent read addresses. In the same cycle, a write address (Z) and a write strobe decide where the result goes. A 16-bit immediate can stand in for the Y operand after sign extension.

Three functional units work on the operands: an adder/subtractor, a bitwise truth-table logic unit and a barrel shifter. Each unit places its output on a shared result bus only while its own enable bit is set. The bus is visible on the ports and is written back into the register file at the next rising clock edge. A controller, or a microprogram sequencer outside this block, builds each operation as one control word: read, compute and write back all happen in one clock cycle.

Top module: `cw_datapath`

## Requirements
- R1: After reset every register reads as zero.
- R2: On a rising edge with `wr_en` high, the register at `dst_z_addr` takes the value of `result_bus`. With `wr_en` low, no register changes.
- R3: Operand X is the register at `src_x_addr`. With `imm_sel` low, operand Y is the register at `src_y_addr`. Both operands reflect register contents from before the current cycle's write.
- R4: With `imm_sel` high, operand Y is `imm_value` sign-extended: bit 15 is copied into bits 31..16.
- R5: With `imm_sel` low, `imm_value` has no effect on the result.
- R6: With `arith_en` high, the bus carries X+Y when `arith_sub` is 0 and X−Y (two's complement, modulo 2^32) when `arith_sub` is 1.
- R7: With `logic_en` high, each bus bit k equals `logic_tt[{X[k],Y[k]}]`. For example, 4'b0110 gives XOR, 4'b1000 gives AND, 4'b1110 gives OR and 4'b1100 passes X.
- R8: With `shift_en` high, X is shifted by the magnitude of Y. The shift goes right when Y is negative (Y[31]=1) and left otherwise. `shift_kind` 0 is logical (zero fill) and 1 is arithmetic (right shifts fill with X[31], left shifts fill with zero). `shift_kind` 2 rotates. Code 3 acts as logical.
- R9: A shift magnitude of 32 or more yields zero for logical shifts and arithmetic left shifts, and 32 copies of X[31] for arithmetic right shifts. A rotation uses the magnitude modulo 32.
- R10: At most one of `arith_en`, `logic_en`, `shift_en` is high. When none is high the bus carries zero, and a write stores zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_x_addr | input | 5 | Read address of operand X |
| src_y_addr | input | 5 | Read address of operand Y |
| dst_z_addr | input | 5 | Write-back address |
| wr_en | input | 1 | Register write strobe |
| imm_sel | input | 1 | Use the sign-extended immediate as Y |
| imm_value | input | 16 | Immediate value |
| arith_en | input | 1 | Arithmetic unit drives the bus |
| arith_sub | input | 1 | 0 add, 1 subtract |
| logic_en | input | 1 | Logic unit drives the bus |
| logic_tt | input | 4 | Truth table indexed by {X[k],Y[k]} |
| shift_en | input | 1 | Shifter drives the bus |
| shift_kind | input | 2 | 0 logical, 1 arithmetic, 2 rotate, 3 logical |
| result_bus | output | 32 | Shared result bus, also the write-back data |

## Verification
A register read and a register write can happen in the same cycle, and can target the same register. The bench provokes this with a control word whose X source and Z destination are the same register (for example, incrementing R1 by an immediate). It checks that the bus shows the sum formed from the old contents before the edge. It then reads the register back and checks that it holds that sum afterwards. A second case writes a register while the next control word reads it immediately, which confirms that the new value is visible from the following cycle on.

// File: rtl/cwdp_pkg.sv
package cwdp_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned REG_NUM = 32;
    localparam int unsigned IMM_W   = 16;

    typedef enum logic [1:0] {
        SHK_LOGICAL = 2'd0,
        SHK_ARITH   = 2'd1,
        SHK_ROTATE  = 2'd2,
        SHK_SPARE   = 2'd3
    } shift_kind_e;
endpackage

// File: rtl/cwdp_arith.sv
module cwdp_arith #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] opb_eff;
    always_comb begin
        opb_eff = sub ? ~opb : opb;
        sum     = opa + opb_eff + {{(W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/cwdp_logic.sv
module cwdp_logic #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [3:0]   table_bits,
    output logic [W-1:0] res
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        assign res[k] = table_bits[{opa[k], opb[k]}];
    end
endmodule

// File: rtl/cwdp_shifter.sv
module cwdp_shifter
    import cwdp_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] amount,
    input  shift_kind_e  kind,
    output logic [W-1:0] res
);
    localparam int unsigned STAGES = $clog2(W);

    logic         go_right;
    logic         is_rot;
    logic         is_arith;
    logic [W-1:0] magnitude;
    logic         over_range;
    logic [W-1:0] stg [STAGES+1];

    always_comb begin
        go_right   = amount[W-1];
        is_rot     = (kind == SHK_ROTATE);
        is_arith   = (kind == SHK_ARITH);
        magnitude  = go_right ? (~amount + {{(W-1){1'b0}}, 1'b1}) : amount;
        over_range = |magnitude[W-1:STAGES];
        stg[0]     = data;
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        localparam int unsigned S = 1 << i;
        logic [W-1:0] moved;
        always_comb begin
            if (go_right) begin
                if (is_rot)
                    moved = {stg[i][S-1:0], stg[i][W-1:S]};
                else if (is_arith)
                    moved = {{S{stg[i][W-1]}}, stg[i][W-1:S]};
                else
                    moved = {{S{1'b0}}, stg[i][W-1:S]};
            end else begin
                if (is_rot)
                    moved = {stg[i][W-S-1:0], stg[i][W-1:W-S]};
                else
                    moved = {stg[i][W-S-1:0], {S{1'b0}}};
            end
            stg[i+1] = magnitude[i] ? moved : stg[i];
        end
    end

    always_comb begin
        if (!over_range || is_rot)
            res = stg[STAGES];
        else if (is_arith && go_right)
            res = {W{data[W-1]}};
        else
            res = '0;
    end
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
    import cwdp_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned N  = REG_NUM,
    parameter int unsigned IW = IMM_W,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src_x_addr,
    input  logic [AW-1:0] src_y_addr,
    input  logic [AW-1:0] dst_z_addr,
    input  logic          wr_en,
    input  logic          imm_sel,
    input  logic [IW-1:0] imm_value,
    input  logic          arith_en,
    input  logic          arith_sub,
    input  logic          logic_en,
    input  logic [3:0]    logic_tt,
    input  logic          shift_en,
    input  logic [1:0]    shift_kind,
    output logic [W-1:0]  result_bus
);
    logic [N-1:0][W-1:0] rf_d, rf_q;
    logic [W-1:0] x_opnd, y_opnd, imm_ext;
    logic [W-1:0] arith_out, logic_out, shift_out;

    always_comb begin
        imm_ext = {{(W-IW){imm_value[IW-1]}}, imm_value};
        x_opnd  = rf_q[src_x_addr];
        y_opnd  = imm_sel ? imm_ext : rf_q[src_y_addr];
    end

    cwdp_arith #(.W(W)) u_arith (
        .opa(x_opnd), .opb(y_opnd), .sub(arith_sub), .sum(arith_out)
    );

    cwdp_logic #(.W(W)) u_logic (
        .opa(x_opnd), .opb(y_opnd), .table_bits(logic_tt), .res(logic_out)
    );

    cwdp_shifter #(.W(W)) u_shift (
        .data(x_opnd), .amount(y_opnd), .kind(shift_kind_e'(shift_kind)), .res(shift_out)
    );

    always_comb begin
        result_bus = ({W{arith_en}} & arith_out)
                   | ({W{logic_en}} & logic_out)
                   | ({W{shift_en}} & shift_out);
        rf_d = rf_q;
        if (wr_en)
            rf_d[dst_z_addr] = result_bus;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rf_q <= '0;
        else
            rf_q <= rf_d;
    end
endmodule

// File: rtl/cwdp_checker.sv
module cwdp_checker #(
    parameter int unsigned W  = 32,
    parameter int unsigned N  = 32,
    parameter int unsigned IW = 16,
    parameter int unsigned AW = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       dst_z_addr,
    input logic                wr_en,
    input logic                imm_sel,
    input logic [IW-1:0]       imm_value,
    input logic                arith_en,
    input logic                arith_sub,
    input logic                logic_en,
    input logic [3:0]          logic_tt,
    input logic                shift_en,
    input logic [W-1:0]        x_opnd,
    input logic [W-1:0]        y_opnd,
    input logic [W-1:0]        result_bus,
    input logic [N-1:0][W-1:0] rf_q
);
    assert_enable_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arith_en, logic_en, shift_en}));

    assert_idle_bus_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(arith_en || logic_en || shift_en) |-> (result_bus == '0));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rf_q[$past(dst_z_addr)] == $past(result_bus)));

    assert_no_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rf_q));

    assert_imm_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_en && !arith_sub && imm_sel) |->
        (result_bus == x_opnd + {{(W-IW){imm_value[IW-1]}}, imm_value}));

    assert_xor_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (logic_en && logic_tt == 4'b0110) |-> (result_bus == (x_opnd ^ y_opnd)));
endmodule

bind cw_datapath cwdp_checker #(.W(W), .N(N), .IW(IW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dst_z_addr(dst_z_addr), .wr_en(wr_en),
    .imm_sel(imm_sel), .imm_value(imm_value), .arith_en(arith_en),
    .arith_sub(arith_sub), .logic_en(logic_en), .logic_tt(logic_tt),
    .shift_en(shift_en), .x_opnd(x_opnd), .y_opnd(y_opnd),
    .result_bus(result_bus), .rf_q(rf_q)
);

// File: tb/cw_datapath_tb_top.sv
`timescale 1ns/1ps
module cw_datapath_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  xa = '0, ya = '0, za = '0;
    logic        we = 1'b0, isel = 1'b0;
    logic [15:0] imm = '0;
    logic        aen = 1'b0, asub = 1'b0, len = 1'b0, sen = 1'b0;
    logic [3:0]  tt = '0;
    logic [1:0]  sk = '0;
    logic [31:0] bus;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    cw_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .src_x_addr(xa), .src_y_addr(ya),
        .dst_z_addr(za), .wr_en(we), .imm_sel(isel), .imm_value(imm),
        .arith_en(aen), .arith_sub(asub), .logic_en(len), .logic_tt(tt),
        .shift_en(sen), .shift_kind(sk), .result_bus(bus)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Present one control word at the falling edge; return the bus value before the write edge.
    task automatic issue(input logic [4:0] x, input logic [4:0] y, input logic [4:0] z,
                         input logic w, input logic is, input logic [15:0] iv,
                         input logic ae, input logic as_, input logic le,
                         input logic [3:0] t, input logic se, input logic [1:0] k,
                         output logic [31:0] seen);
        @(negedge clk);
        xa = x; ya = y; za = z; we = w; isel = is; imm = iv;
        aen = ae; asub = as_; len = le; tt = t; sen = se; sk = k;
        #1 seen = bus;
    endtask

    // Read a register through the logic unit (pass X), no write.
    task automatic peek(input logic [4:0] r, output logic [31:0] v);
        issue(r, 5'd0, 5'd0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 4'b1100, 1'b0, 2'd0, v);
    endtask

    task automatic load_imm(input logic [4:0] z, input logic [15:0] v);
        logic [31:0] s;
        issue(5'd0, 5'd0, z, 1'b1, 1'b1, v, 1'b1, 1'b0, 1'b0, 4'b0, 1'b0, 2'd0, s);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        peek(5'd0, v);  check("R1 reg0 zero", v, 32'h0);
        peek(5'd31, v); check("R1 reg31 zero", v, 32'h0);
    endtask

    task automatic t_imm_add;
        logic [31:0] s, v;
        issue(5'd0, 5'd0, 5'd1, 1'b1, 1'b1, 16'h1234, 1'b1, 1'b0, 1'b0, 4'b0, 1'b0, 2'd0, s);
        check("R6 add imm bus", s, 32'h0000_1234);
        peek(5'd1, v); check("R2 add imm writeback", v, 32'h0000_1234);
        issue(5'd0, 5'd0, 5'd2, 1'b1, 1'b1, 16'hFFF0, 1'b1, 1'b0, 1'b0, 4'b0, 1'b0, 2'd0, s);
        check("R4 sign-extended imm", s, 32'hFFFF_FFF0);
        peek(5'd2, v); check("R2 neg imm writeback", v, 32'hFFFF_FFF0);
    endtask

    task automatic t_arith;
        logic [31:0] s, v;
        issue(5'd1, 5'd2, 5'd4, 1'b1, 1'b0, 16'h7777, 1'b1, 1'b1, 1'b0, 4'b0, 1'b0, 2'd0, s);
        check("R6 sub regs (R5 imm ignored)", s, 32'h0000_1244);
        peek(5'd4, v); check("R2 sub writeback", v, 32'h0000_1244);
        issue(5'd2, 5'd2, 5'd0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 4'b0, 1'b0, 2'd0, s);
        check("R6 add wraps", s, 32'hFFFF_FFE0);
    endtask

    task automatic t_logic;
        logic [31:0] s, v;
        issue(5'd1, 5'd2, 5'd3, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 4'b0110, 1'b0, 2'd0, s);
        check("R7 xor bus", s, 32'hFFFF_EDC4);
        peek(5'd3, v); check("R7 xor writeback", v, 32'hFFFF_EDC4);
        issue(5'd1, 5'd3, 5'd0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 4'b1000, 1'b0, 2'd0, s);
        check("R7 and", s, 32'h0000_0004);
        issue(5'd1, 5'd3, 5'd0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 4'b1110, 1'b0, 2'd0, s);
        check("R7 or", s, 32'hFFFF_FFF4);
        issue(5'd1, 5'd0, 5'd0, 1'b0, 1'b1, 16'h00FF, 1'b0, 1'b0, 1'b1, 4'b0001, 1'b0, 2'd0, s);
        check("R7 nor with imm", s, 32'hFFFF_ED00);
    endtask

    task automatic t_shift;
        logic [31:0] s, v;
        issue(5'd1, 5'd0, 5'd5, 1'b1, 1'b1, 16'd4, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd0, s);
        check("R8 logical left", s, 32'h0001_2340);
        peek(5'd5, v); check("R8 shift writeback", v, 32'h0001_2340);
        issue(5'd2, 5'd0, 5'd0, 1'b0, 1'b1, 16'hFFFC, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd0, s);
        check("R8 logical right", s, 32'h0FFF_FFFF);
        issue(5'd2, 5'd0, 5'd0, 1'b0, 1'b1, 16'hFFFC, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd1, s);
        check("R8 arith right", s, 32'hFFFF_FFFF);
        issue(5'd1, 5'd0, 5'd0, 1'b0, 1'b1, 16'hFFFC, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd2, s);
        check("R8 rotate right", s, 32'h4000_0123);
        issue(5'd2, 5'd0, 5'd0, 1'b0, 1'b1, 16'd8, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd2, s);
        check("R8 rotate left", s, 32'hFFFF_F0FF);
        load_imm(5'd7, 16'd8);
        issue(5'd1, 5'd7, 5'd0, 1'b0, 1'b0, 16'h0003, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd0, s);
        check("R3 shift amount from reg", s, 32'h0012_3400);
        issue(5'd1, 5'd0, 5'd0, 1'b0, 1'b1, 16'd0, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd3, s);
        check("R8 zero shift", s, 32'h0000_1234);
    endtask

    task automatic t_range;
        logic [31:0] s;
        issue(5'd1, 5'd0, 5'd0, 1'b0, 1'b1, 16'd40, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd0, s);
        check("R9 left over range", s, 32'h0);
        issue(5'd2, 5'd0, 5'd0, 1'b0, 1'b1, 16'hFFD8, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd1, s);
        check("R9 arith right over range", s, 32'hFFFF_FFFF);
        issue(5'd1, 5'd0, 5'd0, 1'b0, 1'b1, 16'hFFD8, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd1, s);
        check("R9 arith right over range positive", s, 32'h0);
        issue(5'd1, 5'd0, 5'd0, 1'b0, 1'b1, 16'd36, 1'b0, 1'b0, 1'b0, 4'b0, 1'b1, 2'd2, s);
        check("R9 rotate modulo", s, 32'h0001_2340);
    endtask

    task automatic t_write_ctl;
        logic [31:0] s, v;
        issue(5'd1, 5'd0, 5'd3, 1'b0, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, 4'b0, 1'b0, 2'd0, s);
        peek(5'd3, v); check("R2 no write keeps reg", v, 32'hFFFF_EDC4);
        issue(5'd1, 5'd0, 5'd4, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 4'b0, 1'b0, 2'd0, s);
        check("R10 idle bus zero", s, 32'h0);
        peek(5'd4, v); check("R10 idle write stores zero", v, 32'h0);
    endtask

    task automatic t_same_cycle;
        logic [31:0] s, v;
        issue(5'd1, 5'd0, 5'd1, 1'b1, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, 4'b0, 1'b0, 2'd0, s);
        check("R3 read old value in write cycle", s, 32'h0000_1235);
        issue(5'd1, 5'd0, 5'd1, 1'b1, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, 4'b0, 1'b0, 2'd0, s);
        check("R3 next cycle sees new value", s, 32'h0000_1236);
        peek(5'd1, v); check("R2 back-to-back writeback", v, 32'h0000_1236);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_imm_add();
        t_arith();
        t_logic();
        t_shift();
        t_range();
        t_write_ctl();
        t_same_cycle();
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule